// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of page translations. Each line holds one 4 KiB page mapping. The mapping is tagged with a 7-bit address-space identifier (ASID) and the virtual page number (virtual address bits [31:12]). The line carries a 20-bit physical frame number and three permission flags: read, write and non-secure. Clients present an ASID and a virtual address on the lookup port and receive a registered answer one cycle later. After a miss, a page-table walker returns the mapping through the fill port.

Stale mappings are removed with a 32-bit invalidation command. The command can clear every line, or every line of one ASID. It can also clear the lines whose virtual address falls in one 4 MiB section or in one 16 KiB group, with or without an ASID qualifier. Two configuration inputs shape the cache:
- One limits how many lines are in service.
- The other lets lookups continue while a miss is waiting for its fill.

Top module: `asid_tlb`

## Requirements
- R1: After reset no line is valid, no miss is pending and `rsp_valid` is low. A lookup accepted at a clock edge (`lk_valid` and `lk_ready` high) gives `rsp_valid` high for exactly the following cycle. Without an accepted lookup, `rsp_valid` stays low.
- R2: A lookup hits when a valid line in service holds the same ASID and the same virtual address bits [31:12]. On a hit the response returns that line's frame number and its read, write and non-secure flags. Any other lookup answers with `rsp_hit` low.
- R3: An invalidation command with bits [1:0] = 0 and bit 31 clear clears every line.
- R4: When bit 31 of the command is set, only lines whose ASID equals command bits [30:24] are cleared, whatever the address mode.
- R5: Command mode 2 clears lines whose virtual address bits [31:22] equal command bits [19:10]. Mode 3 clears lines whose virtual address bits [31:14] equal command bits [19:2]. Mode 1 clears nothing.
- R6: `cfg_active_lines` sets how many lines are in service. A line at or above that index never hits and is never written by a fill. With a count of 0, fills are dropped.
- R7: A fill whose ASID and page already match a valid line in service rewrites that line in place. It does not take a second line.
- R8: A fill that matches no line writes the line under a round-robin pointer. The pointer starts at line 0 after reset, advances only on such allocating fills, and wraps within the lines in service.
- R9: With `cfg_hum` high, lookups are accepted while a miss is pending, and hits are answered normally. With `cfg_hum` low, `lk_ready` is low from the cycle after a missing lookup until the cycle after the next fill.
- R10: An invalidation takes effect at the clock edge where it is presented. A lookup presented in the same cycle sees the lines as they were before it. A fill presented in the same cycle is written after the invalidation and survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hum | input | 1 | Allow lookups while a miss is outstanding |
| cfg_active_lines | input | 4 | Number of lines in service (0 to NUM_LINES) |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_pfn | output | 20 | Physical frame number on a hit, zero otherwise |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ns | output | 1 | Non-secure mapping |
| fill_valid | input | 1 | Fill from the page-table walker |
| fill_asid | input | 7 | Fill address-space identifier |
| fill_va | input | 32 | Fill virtual address |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_rd | input | 1 | Fill read permission |
| fill_wr | input | 1 | Fill write permission |
| fill_ns | input | 1 | Fill non-secure flag |
| flush_valid | input | 1 | Invalidation command strobe |
| flush_cmd | input | 32 | Invalidation command word |

## Verification
A lookup answer is due on the first clock edge after the request is accepted. The checks drive the request on a falling edge, let one rising edge pass and read `rsp_*` on the next falling edge. Fills and invalidations change the lines at the single edge where they are presented. Their effect is therefore checked through a lookup issued after that edge, except in the same-cycle cases of R10, where lookup and invalidation share one edge on purpose. The stall flag behind `lk_ready` is registered, so it is read one falling edge after the missing lookup or the fill that changes it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ASID_W        = 7;
    localparam int VA_W          = 32;
    localparam int PAGE_SHIFT    = 12;
    localparam int SECTION_SHIFT = 22;
    localparam int GROUP_SHIFT   = 14;
    localparam int VPN_W         = VA_W - PAGE_SHIFT;
    localparam int PFN_W         = 20;
    localparam int CMD_W         = 32;
    localparam int CMD_QUAL_BIT  = 31;
    localparam int CMD_ASID_LSB  = 24;

    typedef enum logic [1:0] {
        FLM_ALL     = 2'd0,
        FLM_RSVD    = 2'd1,
        FLM_SECTION = 2'd2,
        FLM_GROUP   = 2'd3
    } flush_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ns;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
    } tlb_line_t;

    typedef struct packed {
        logic              active;
        logic              asid_qual;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn_mask;
        logic [VPN_W-1:0]  vpn_ref;
    } kill_req_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } tlb_rsp_t;

endpackage

// File: rtl/tlb_flush_decode.sv
module tlb_flush_decode
    import tlb_pkg::*;
(
    input  logic             flush_valid,
    input  logic [CMD_W-1:0] flush_cmd,
    output kill_req_t        kill
);

    localparam int SEC_LOW = SECTION_SHIFT - PAGE_SHIFT;
    localparam int GRP_LOW = GROUP_SHIFT - PAGE_SHIFT;
    localparam logic [VPN_W-1:0] SEC_MASK = ~((VPN_W'(1) << SEC_LOW) - VPN_W'(1));
    localparam logic [VPN_W-1:0] GRP_MASK = ~((VPN_W'(1) << GRP_LOW) - VPN_W'(1));

    flush_mode_e mode;
    logic        unused_cmd_bits;

    assign mode            = flush_mode_e'(flush_cmd[1:0]);
    assign unused_cmd_bits = ^flush_cmd[CMD_ASID_LSB-1:VPN_W];

    always_comb begin
        kill           = '0;
        kill.asid_qual = flush_cmd[CMD_QUAL_BIT];
        kill.asid      = flush_cmd[CMD_ASID_LSB +: ASID_W];
        kill.vpn_ref   = flush_cmd[VPN_W-1:0];
        unique case (mode)
            FLM_ALL: begin
                kill.active   = flush_valid;
                kill.vpn_mask = '0;
            end
            FLM_SECTION: begin
                kill.active   = flush_valid;
                kill.vpn_mask = SEC_MASK;
            end
            FLM_GROUP: begin
                kill.active   = flush_valid;
                kill.vpn_mask = GRP_MASK;
            end
            default: begin
                kill.active   = 1'b0;
                kill.vpn_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/tlb_line_match.sv
module tlb_line_match
    import tlb_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
    input  tlb_line_t [NUM_LINES-1:0] lines,
    input  logic [CNT_W-1:0]          active_lines,
    input  logic [ASID_W-1:0]         lk_asid,
    input  logic [VPN_W-1:0]          lk_vpn,
    input  logic [ASID_W-1:0]         fill_asid,
    input  logic [VPN_W-1:0]          fill_vpn,
    input  kill_req_t                 kill,
    output logic [NUM_LINES-1:0]      lk_hit_vec,
    output logic [NUM_LINES-1:0]      fill_hit_vec,
    output logic [NUM_LINES-1:0]      kill_vec
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [CNT_W-1:0] LINE_IDX = CNT_W'(g);
        logic in_service;
        logic asid_ok;
        logic addr_ok;

        assign in_service = lines[g].valid && (LINE_IDX < active_lines);
        assign lk_hit_vec[g]   = in_service && (lines[g].asid == lk_asid)
                                 && (lines[g].vpn == lk_vpn);
        assign fill_hit_vec[g] = in_service && (lines[g].asid == fill_asid)
                                 && (lines[g].vpn == fill_vpn);
        assign asid_ok = !kill.asid_qual || (lines[g].asid == kill.asid);
        assign addr_ok = ((lines[g].vpn ^ kill.vpn_ref) & kill.vpn_mask) == '0;
        assign kill_vec[g] = kill.active && lines[g].valid && asid_ok && addr_ok;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = $clog2(NUM_LINES + 1),
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] fill_hit_vec,
    input  logic [IDX_W-1:0]     rr_q,
    input  logic [CNT_W-1:0]     active_lines,
    output logic                 fill_ok,
    output logic                 alloc,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [IDX_W-1:0]     rr_next
);

    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim;
    logic [CNT_W-1:0] victim_inc;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (fill_hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        fill_ok    = (active_lines != '0);
        alloc      = (fill_hit_vec == '0);
        victim     = (CNT_W'(rr_q) < active_lines) ? rr_q : '0;
        victim_inc = CNT_W'(victim) + CNT_W'(1);
        rr_next    = (victim_inc >= active_lines) ? '0 : IDX_W'(victim_inc);
        wr_idx     = alloc ? victim : hit_idx;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = $clog2(NUM_LINES + 1),
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hum,
    input  logic [CNT_W-1:0]  cfg_active_lines,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ns,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              fill_ns,
    input  logic              flush_valid,
    input  logic [CMD_W-1:0]  flush_cmd
);

    typedef struct packed {
        tlb_line_t [NUM_LINES-1:0] lines;
        logic [IDX_W-1:0]          rr;
        logic                      pend;
        tlb_rsp_t                  rsp;
    } state_t;

    state_t st_d, st_q;

    kill_req_t            kill;
    logic [NUM_LINES-1:0] lk_hit_vec;
    logic [NUM_LINES-1:0] fill_hit_vec;
    logic [NUM_LINES-1:0] kill_vec;
    logic [NUM_LINES-1:0] line_valid;
    logic                 fill_ok;
    logic                 alloc;
    logic [IDX_W-1:0]     wr_idx;
    logic [IDX_W-1:0]     rr_next;
    logic                 lk_fire;
    logic                 pend_q;
    logic [PFN_W-1:0]     hit_pfn;
    perm_t                hit_perm;
    logic                 unused_va_bits;

    assign unused_va_bits = ^{lk_va[PAGE_SHIFT-1:0], fill_va[PAGE_SHIFT-1:0]};

    tlb_flush_decode u_decode (
        .flush_valid (flush_valid),
        .flush_cmd   (flush_cmd),
        .kill        (kill)
    );

    tlb_line_match #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W)
    ) u_match (
        .lines        (st_q.lines),
        .active_lines (cfg_active_lines),
        .lk_asid      (lk_asid),
        .lk_vpn       (lk_va[VA_W-1:PAGE_SHIFT]),
        .fill_asid    (fill_asid),
        .fill_vpn     (fill_va[VA_W-1:PAGE_SHIFT]),
        .kill         (kill),
        .lk_hit_vec   (lk_hit_vec),
        .fill_hit_vec (fill_hit_vec),
        .kill_vec     (kill_vec)
    );

    tlb_victim #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_victim (
        .fill_hit_vec (fill_hit_vec),
        .rr_q         (st_q.rr),
        .active_lines (cfg_active_lines),
        .fill_ok      (fill_ok),
        .alloc        (alloc),
        .wr_idx       (wr_idx),
        .rr_next      (rr_next)
    );

    assign pend_q   = st_q.pend;
    assign lk_ready = !st_q.pend || cfg_hum;
    assign lk_fire  = lk_valid && lk_ready;

    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            line_valid[i] = st_q.lines[i].valid;
            if (lk_hit_vec[i]) begin
                hit_pfn  = hit_pfn | st_q.lines[i].pfn;
                hit_perm = hit_perm | st_q.lines[i].perm;
            end
        end
    end

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < NUM_LINES; i++) begin
            if (kill_vec[i]) st_d.lines[i].valid = 1'b0;
        end

        if (fill_valid && fill_ok) begin
            st_d.lines[wr_idx].valid   = 1'b1;
            st_d.lines[wr_idx].asid    = fill_asid;
            st_d.lines[wr_idx].vpn     = fill_va[VA_W-1:PAGE_SHIFT];
            st_d.lines[wr_idx].pfn     = fill_pfn;
            st_d.lines[wr_idx].perm.rd = fill_rd;
            st_d.lines[wr_idx].perm.wr = fill_wr;
            st_d.lines[wr_idx].perm.ns = fill_ns;
            if (alloc) st_d.rr = rr_next;
        end

        if (fill_valid) st_d.pend = 1'b0;
        if (lk_fire && (lk_hit_vec == '0)) st_d.pend = 1'b1;

        st_d.rsp.valid = lk_fire;
        st_d.rsp.hit   = lk_fire && (lk_hit_vec != '0);
        st_d.rsp.pfn   = lk_fire ? hit_pfn : '0;
        st_d.rsp.perm  = lk_fire ? hit_perm : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp.valid;
    assign rsp_hit   = st_q.rsp.hit;
    assign rsp_pfn   = st_q.rsp.pfn;
    assign rsp_rd    = st_q.rsp.perm.rd;
    assign rsp_wr    = st_q.rsp.perm.wr;
    assign rsp_ns    = st_q.rsp.perm.ns;

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_hum,
    input logic [CNT_W-1:0]     cfg_active_lines,
    input logic                 lk_valid,
    input logic                 lk_ready,
    input logic                 rsp_valid,
    input logic                 fill_valid,
    input logic                 flush_valid,
    input logic [31:0]          flush_cmd,
    input logic [NUM_LINES-1:0] lk_hit_vec,
    input logic [NUM_LINES-1:0] line_valid
);

    logic beyond_hit;

    always_comb begin
        beyond_hit = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if ((CNT_W'(i) >= cfg_active_lines) && lk_hit_vec[i]) beyond_hit = 1'b1;
        end
    end

    AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid); // R1

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid); // R1

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R7

    AST_INACTIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !beyond_hit); // R6

    AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_cmd[31] && (flush_cmd[1:0] == 2'd0) && !fill_valid)
        |=> (line_valid == '0)); // R3

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && (lk_hit_vec == '0) && !fill_valid && !cfg_hum)
        |=> !lk_ready); // R9

endmodule

bind asid_tlb asid_tlb_checker #(
    .NUM_LINES (NUM_LINES),
    .CNT_W     (CNT_W)
) u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_hum          (cfg_hum),
    .cfg_active_lines (cfg_active_lines),
    .lk_valid         (lk_valid),
    .lk_ready         (lk_ready),
    .rsp_valid        (rsp_valid),
    .fill_valid       (fill_valid),
    .flush_valid      (flush_valid),
    .flush_cmd        (flush_cmd),
    .lk_hit_vec       (lk_hit_vec),
    .line_valid       (line_valid)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_hum;
    logic [3:0]  cfg_active_lines;
    logic        lk_valid;
    logic        lk_ready;
    logic [6:0]  lk_asid;
    logic [31:0] lk_va;
    logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ns;
    logic [19:0] rsp_pfn;
    logic        fill_valid;
    logic [6:0]  fill_asid;
    logic [31:0] fill_va;
    logic [19:0] fill_pfn;
    logic        fill_rd, fill_wr, fill_ns;
    logic        flush_valid;
    logic [31:0] flush_cmd;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    asid_tlb u_asid_tlb (
        .clk (clk), .rst_n (rst_n), .cfg_hum (cfg_hum),
        .cfg_active_lines (cfg_active_lines),
        .lk_valid (lk_valid), .lk_ready (lk_ready), .lk_asid (lk_asid), .lk_va (lk_va),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_pfn (rsp_pfn),
        .rsp_rd (rsp_rd), .rsp_wr (rsp_wr), .rsp_ns (rsp_ns),
        .fill_valid (fill_valid), .fill_asid (fill_asid), .fill_va (fill_va),
        .fill_pfn (fill_pfn), .fill_rd (fill_rd), .fill_wr (fill_wr), .fill_ns (fill_ns),
        .flush_valid (flush_valid), .flush_cmd (flush_cmd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [6:0] a, input logic [31:0] va,
                           input logic [19:0] pfn, input logic [2:0] perm);
        fill_valid = 1'b1; fill_asid = a; fill_va = va; fill_pfn = pfn;
        {fill_rd, fill_wr, fill_ns} = perm;
        step();
        fill_valid = 1'b0;
    endtask

    task automatic do_flush(input logic [31:0] cmd);
        flush_valid = 1'b1; flush_cmd = cmd;
        step();
        flush_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [6:0] a, input logic [31:0] va);
        lk_valid = 1'b1; lk_asid = a; lk_va = va;
        step();
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [6:0] a, input logic [31:0] va,
                              input logic [19:0] pfn, input logic [2:0] perm);
        do_lookup(a, va);
        chk(req, {rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ns, 7'd0, rsp_pfn},
            {2'b11, perm, 7'd0, pfn});
    endtask

    task automatic expect_miss(input string req, input logic [6:0] a, input logic [31:0] va);
        do_lookup(a, va);
        chk(req, {30'd0, rsp_valid, rsp_hit}, {30'd0, 2'b10});
    endtask

    task automatic t_reset();
        chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 reset ready", {31'd0, lk_ready}, 32'd1);
        expect_miss("R1 empty after reset", 7'd5, 32'h1234_5000);
        step();
        chk("R1 single response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_basic_hit();
        do_flush(32'h0);
        do_fill(7'd5, 32'h1234_5000, 20'hABCDE, 3'b101);
        expect_hit("R2 basic hit", 7'd5, 32'h1234_5FFC, 20'hABCDE, 3'b101);
        expect_miss("R2 other asid", 7'd6, 32'h1234_5000);
        expect_miss("R2 other page", 7'd5, 32'h1234_6000);
    endtask

    task automatic t_refill_and_rr();
        do_flush(32'h0);
        do_fill(7'd9, 32'h0000_A000, 20'h11111, 3'b100);
        do_fill(7'd9, 32'h0000_A000, 20'h22222, 3'b010);
        expect_hit("R7 refill in place", 7'd9, 32'h0000_A000, 20'h22222, 3'b010);
        for (int i = 1; i < NL; i++) do_fill(7'd9, 32'h0010_0000 + (i << 12), 20'(i), 3'b111);
        expect_hit("R7 no line lost", 7'd9, 32'h0000_A000, 20'h22222, 3'b010);
        do_fill(7'd9, 32'h00F0_0000, 20'h0F0F0, 3'b111);
        expect_miss("R8 oldest evicted", 7'd9, 32'h0000_A000);
        expect_hit("R8 next kept", 7'd9, 32'h0010_1000, 20'h00001, 3'b111);
        expect_hit("R8 new line", 7'd9, 32'h00F0_0000, 20'h0F0F0, 3'b111);
    endtask

    task automatic t_active_lines();
        do_flush(32'h0);
        cfg_active_lines = 4'd2;
        do_fill(7'd2, 32'h0000_1000, 20'h00001, 3'b111);
        do_fill(7'd2, 32'h0000_2000, 20'h00002, 3'b111);
        do_fill(7'd2, 32'h0000_3000, 20'h00003, 3'b111);
        expect_miss("R6 two lines only", 7'd2, 32'h0000_1000);
        expect_hit("R6 second kept", 7'd2, 32'h0000_2000, 20'h00002, 3'b111);
        expect_hit("R6 third kept", 7'd2, 32'h0000_3000, 20'h00003, 3'b111);
        cfg_active_lines = 4'd0;
        do_fill(7'd2, 32'h0000_4000, 20'h00004, 3'b111);
        expect_miss("R6 zero lines no hit", 7'd2, 32'h0000_2000);
        cfg_active_lines = 4'd8;
        expect_miss("R6 zero lines drop fill", 7'd2, 32'h0000_4000);
    endtask

    task automatic t_flush_all_and_asid();
        do_flush(32'h0);
        do_fill(7'd1, 32'h0005_0000, 20'h00050, 3'b110);
        do_fill(7'd2, 32'h0005_0000, 20'h00051, 3'b110);
        do_flush(32'h8100_0000);
        expect_miss("R4 asid 1 cleared", 7'd1, 32'h0005_0000);
        expect_hit("R4 asid 2 kept", 7'd2, 32'h0005_0000, 20'h00051, 3'b110);
        do_fill(7'd3, 32'h0006_0000, 20'h00060, 3'b001);
        do_flush(32'h0000_0000);
        expect_miss("R3 all cleared a", 7'd2, 32'h0005_0000);
        expect_miss("R3 all cleared b", 7'd3, 32'h0006_0000);
    endtask

    task automatic t_section_group();
        do_flush(32'h0);
        do_fill(7'd3, 32'h0040_0000, 20'h00100, 3'b111);
        do_fill(7'd3, 32'h0040_1000, 20'h00101, 3'b111);
        do_fill(7'd3, 32'h0080_0000, 20'h00102, 3'b111);
        do_fill(7'd4, 32'h0040_2000, 20'h00103, 3'b111);
        do_flush(32'h8300_0402);
        expect_miss("R5 section cleared a", 7'd3, 32'h0040_0000);
        expect_miss("R5 section cleared b", 7'd3, 32'h0040_1000);
        expect_hit("R5 other section kept", 7'd3, 32'h0080_0000, 20'h00102, 3'b111);
        expect_hit("R4 section other asid kept", 7'd4, 32'h0040_2000, 20'h00103, 3'b111);
        do_fill(7'd4, 32'h0100_4000, 20'h00200, 3'b011);
        do_fill(7'd5, 32'h0100_7000, 20'h00201, 3'b011);
        do_fill(7'd4, 32'h0100_8000, 20'h00202, 3'b011);
        do_flush(32'h0000_1007);
        expect_miss("R5 group cleared a", 7'd4, 32'h0100_4000);
        expect_miss("R5 group cleared b", 7'd5, 32'h0100_7000);
        expect_hit("R5 next group kept", 7'd4, 32'h0100_8000, 20'h00202, 3'b011);
        do_flush(32'h8400_0001);
        expect_hit("R5 mode 1 no effect", 7'd4, 32'h0100_8000, 20'h00202, 3'b011);
    endtask

    task automatic t_same_cycle();
        do_flush(32'h0);
        do_fill(7'd7, 32'h0777_7000, 20'h07777, 3'b100);
        lk_valid = 1'b1; lk_asid = 7'd7; lk_va = 32'h0777_7000;
        flush_valid = 1'b1; flush_cmd = 32'h0;
        step();
        lk_valid = 1'b0; flush_valid = 1'b0;
        chk("R10 lookup sees old line", {29'd0, rsp_valid, rsp_hit, rsp_rd}, {29'd0, 3'b111});
        expect_miss("R10 flushed after edge", 7'd7, 32'h0777_7000);
        fill_valid = 1'b1; fill_asid = 7'd7; fill_va = 32'h0888_8000;
        fill_pfn = 20'h08888; {fill_rd, fill_wr, fill_ns} = 3'b010;
        flush_valid = 1'b1; flush_cmd = 32'h0;
        step();
        fill_valid = 1'b0; flush_valid = 1'b0;
        expect_hit("R10 fill survives flush", 7'd7, 32'h0888_8000, 20'h08888, 3'b010);
    endtask

    task automatic t_hit_under_miss();
        do_flush(32'h0);
        cfg_hum = 1'b0;
        do_fill(7'd8, 32'h0000_C000, 20'h0000C, 3'b101);
        chk("R9 ready after fill", {31'd0, lk_ready}, 32'd1);
        expect_miss("R9 miss", 7'd8, 32'h0000_D000);
        chk("R9 stalled", {31'd0, lk_ready}, 32'd0);
        do_lookup(7'd8, 32'h0000_C000);
        chk("R9 no answer while stalled", {31'd0, rsp_valid}, 32'd0);
        do_fill(7'd8, 32'h0000_D000, 20'h0000D, 3'b101);
        chk("R9 released by fill", {31'd0, lk_ready}, 32'd1);
        expect_hit("R9 hit after release", 7'd8, 32'h0000_C000, 20'h0000C, 3'b101);
        cfg_hum = 1'b1;
        expect_miss("R9 miss with hum", 7'd8, 32'h0000_E000);
        chk("R9 ready with hum", {31'd0, lk_ready}, 32'd1);
        expect_hit("R9 hit under miss", 7'd8, 32'h0000_D000, 20'h0000D, 3'b101);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_hum = 1'b1; cfg_active_lines = 4'd8;
        lk_valid = 1'b0; lk_asid = '0; lk_va = '0;
        fill_valid = 1'b0; fill_asid = '0; fill_va = '0; fill_pfn = '0;
        fill_rd = 1'b0; fill_wr = 1'b0; fill_ns = 1'b0;
        flush_valid = 1'b0; flush_cmd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_hit();
        t_refill_and_rr();
        t_active_lines();
        t_flush_all_and_asid();
        t_section_group();
        t_same_cycle();
        t_hit_under_miss();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule